// File: doc/BRIEF.md
# Selectable Fixed Reference Divider

This block divides a reference clock by one of four fixed ratios (4, 16, 64 or 100), chosen by a 2-bit select, and produces a near-square divided output. A 4-bit programmable divide-by-N stage sits beside it. A routing control decides which of the two drives the phase-comparator reference. With cascading on, each rising edge of the fixed divider's output advances the programmable stage, and that stage's zero pulse becomes the reference. With cascading off, the fixed divider's output is the reference. The programmable stage then advances on an independent count-enable input.

The whole block runs in one clock domain. Edges of the divided signal are turned into single-cycle strobes. A new ratio selection is taken only when the count wraps, so a period in progress is never cut short. For example, the ratio 100 turns a 5 MHz source into a 50 kHz reference.

Top module: `refDivTop`

## Requirements
- R1: ratioSel selects the fixed ratio, with ratioSel[1] as the high bit: 00 → 4, 01 → 16, 10 → 64, 11 → 100. divOut repeats with a period of exactly that many clock cycles.
- R2: After the k-th rising clock edge following reset release, divOut equals 1 exactly when (k mod ratio) ≥ ratio/2. Each period is therefore low for ratio/2 cycles, then high for ratio/2 cycles (50 high cycles for ratio 100).
- R3: While rst is high, at the clock edge, the count clears and divOut, progZero and refOut are driven low.
- R4: A change on ratioSel takes effect only when the count wraps from ratio−1 to 0. The period in progress finishes with the old ratio.
- R5: With cascadeEn = 1, the programmable stage advances once per rising edge of divOut, and refOut equals progZero.
- R6: The programmable stage starts empty after reset. An advance while it holds 0 or 1 raises progZero for the next clock cycle and reloads it with progN. Any other advance decrements it. From the second pulse on, progZero therefore pulses once every progN advances.
- R7: A progN value of 0 behaves as 1, so every advance produces a progZero pulse.
- R8: With cascadeEn = 0, refOut equals divOut, and the programmable stage advances on every clock cycle in which extTick is 1.
- R9: With cascadeEn = 1, extTick has no effect on progZero or refOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ratioSel | input | 2 | Fixed ratio select |
| cascadeEn | input | 1 | 1: route divider through programmable stage |
| progN | input | 4 | Programmable stage division value |
| extTick | input | 1 | Advance enable for programmable stage when not cascaded |
| divOut | output | 1 | Fixed divider output |
| progZero | output | 1 | Programmable stage zero pulse |
| refOut | output | 1 | Comparator reference |

## Verification
Each of the four select codes is run for several periods from reset. This separates the ratio decode from the 50 % split of high and low time, including the non-power-of-two ratio 100. A select change in the middle of a period checks that the old ratio holds until the wrap. Cascade runs with values of 3 and 0 show the product period and the zero-as-one case. In cascade mode extTick is held high, which shows whether it leaks into the count. Independent mode uses a sparse extTick pattern, so the programmable stage's count is told apart from divOut, which now drives refOut.

// File: rtl/refDivPkg.sv
package refDivPkg;
  // strobes from the counter control to the output datapath
  typedef struct packed {
    logic wrap;   // count returns to zero at the next edge
    logic rise;   // count reaches half at the next edge
  } divStrobeT;
endpackage

// File: rtl/refDivCtrl.sv
module refDivCtrl
  import refDivPkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int RATIO_A = 4,
  parameter int RATIO_B = 16,
  parameter int RATIO_C = 64,
  parameter int RATIO_D = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratioSel,
  output divStrobeT  strb
);
  logic [CNT_W-1:0] cnt, nextCnt, termCnt, halfCnt;
  logic [1:0]       activeSel;

  always_comb begin
    case (activeSel)
      2'b00:   begin termCnt = CNT_W'(RATIO_A - 1); halfCnt = CNT_W'(RATIO_A / 2); end
      2'b01:   begin termCnt = CNT_W'(RATIO_B - 1); halfCnt = CNT_W'(RATIO_B / 2); end
      2'b10:   begin termCnt = CNT_W'(RATIO_C - 1); halfCnt = CNT_W'(RATIO_C / 2); end
      default: begin termCnt = CNT_W'(RATIO_D - 1); halfCnt = CNT_W'(RATIO_D / 2); end
    endcase
  end

  always_comb begin
    strb.wrap = (cnt == termCnt);
    nextCnt   = strb.wrap ? '0 : cnt + 1'b1;
    strb.rise = (nextCnt == halfCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      activeSel <= ratioSel;
    end else begin
      cnt <= nextCnt;
      if (strb.wrap) activeSel <= ratioSel;
    end
  end

  // R4: the active ratio changes only across a wrap
  p_ratio_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !strb.wrap |=> $stable(activeSel));
  // R1: count never passes the terminal value of the active ratio
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= termCnt);
  // R2: the two strobes never coincide
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(strb.wrap && strb.rise));
endmodule

// File: rtl/refDivData.sv
module refDivData
  import refDivPkg::*;
#(
  parameter int PROG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  divStrobeT         strb,
  input  logic              cascadeEn,
  input  logic [PROG_W-1:0] progN,
  input  logic              extTick,
  output logic              divOut,
  output logic              progZero,
  output logic              refOut
);
  logic [PROG_W-1:0] progCnt, reloadVal;
  logic              advance, emptyNow;

  always_comb begin
    advance   = cascadeEn ? strb.rise : extTick;
    reloadVal = (progN == '0) ? PROG_W'(1) : progN;
    emptyNow  = (progCnt <= PROG_W'(1));
    refOut    = cascadeEn ? progZero : divOut;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divOut   <= 1'b0;
      progCnt  <= '0;
      progZero <= 1'b0;
    end else begin
      if (strb.rise)      divOut <= 1'b1;
      else if (strb.wrap) divOut <= 1'b0;
      progZero <= advance && emptyNow;
      if (advance) progCnt <= emptyNow ? reloadVal : progCnt - 1'b1;
    end
  end

  // R2: a rise strobe is followed by a high divider output
  p_rise_high_r2: assert property (@(posedge clk) disable iff (rst)
    strb.rise |=> divOut);
  // R2: a wrap strobe is followed by a low divider output
  p_wrap_low_r2: assert property (@(posedge clk) disable iff (rst)
    strb.wrap |=> !divOut);
  // R6: a zero pulse always follows an advance
  p_zero_after_adv_r6: assert property (@(posedge clk) disable iff (rst)
    progZero |-> $past(advance));
  // R3: reset leaves every output low
  p_reset_low_r3: assert property (@(posedge clk)
    rst |=> (!divOut && !progZero));
endmodule

// File: rtl/refDivTop.sv
module refDivTop
  import refDivPkg::*;
#(
  parameter int RATIO_A = 4,
  parameter int RATIO_B = 16,
  parameter int RATIO_C = 64,
  parameter int RATIO_D = 100,
  parameter int PROG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ratioSel,
  input  logic              cascadeEn,
  input  logic [PROG_W-1:0] progN,
  input  logic              extTick,
  output logic              divOut,
  output logic              progZero,
  output logic              refOut
);
  localparam int MAX_AB = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
  localparam int MAX_CD = (RATIO_C > RATIO_D) ? RATIO_C : RATIO_D;
  localparam int MAX_R  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_R);

  divStrobeT strb;

  refDivCtrl #(.CNT_W(CNT_W), .RATIO_A(RATIO_A), .RATIO_B(RATIO_B),
               .RATIO_C(RATIO_C), .RATIO_D(RATIO_D)) uCtrl (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .strb(strb));

  refDivData #(.PROG_W(PROG_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .cascadeEn(cascadeEn),
    .progN(progN), .extTick(extTick), .divOut(divOut),
    .progZero(progZero), .refOut(refOut));
endmodule

// File: tb/tb_refDivTop.sv
module tb_refDivTop;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratioSel = 2'b00;
  logic       cascadeEn = 1'b0;
  logic [3:0] progN = 4'd3;
  logic       extTick = 1'b0;
  logic       divOut, progZero, refOut;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  refDivTop dut (.clk(clk), .rst(rst), .ratioSel(ratioSel), .cascadeEn(cascadeEn),
                 .progN(progN), .extTick(extTick), .divOut(divOut),
                 .progZero(progZero), .refOut(refOut));

  always #2.5 clk = ~clk;

  // requirement-level model, updated at each rising edge
  int  mCnt, mRatio, mProg;
  bit  mDiv, mZero;
  function automatic int ratioOf(input logic [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 16;
      2'b10: return 64;
      default: return 100;
    endcase
  endfunction

  always @(posedge clk) begin
    bit adv, rise;
    int nv;
    if (rst) begin
      mCnt = 0; mRatio = ratioOf(ratioSel); mDiv = 0; mZero = 0; mProg = 0;
    end else begin
      if (mCnt == mRatio - 1) begin mCnt = 0; mRatio = ratioOf(ratioSel); end
      else mCnt = mCnt + 1;
      rise = (mCnt == mRatio / 2);
      mDiv = (mCnt >= mRatio / 2);
      adv  = cascadeEn ? rise : extTick;
      mZero = adv && (mProg <= 1);
      if (adv) begin
        nv = (progN == 0) ? 1 : int'(progN);
        mProg = (mProg <= 1) ? nv : mProg - 1;
      end
    end
  end

  // period tracking on the observed outputs
  int cyc = 0, divRise = -1, divPer = 0, refRise = -1, refPer = 0, zRise = -1, zPer = 0;
  int highCnt = 0;
  bit pDiv = 0, pRef = 0, pZ = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic clearTrack();
    divRise = -1; divPer = 0; refRise = -1; refPer = 0; zRise = -1; zPer = 0;
    pDiv = 0; pRef = 0; pZ = 0; highCnt = 0;
  endtask

  // one cycle: wait for falling edge, compare against model, track periods
  task automatic step(input string tag);
    @(negedge clk);
    cyc++;
    check(divOut == mDiv, {tag, " divOut"}, int'(divOut), int'(mDiv));
    check(progZero == mZero, {tag, " progZero"}, int'(progZero), int'(mZero));
    check(refOut == (cascadeEn ? mZero : mDiv), {tag, " refOut"}, int'(refOut),
          int'(cascadeEn ? mZero : mDiv));
    if (divOut) highCnt++;
    if (divOut && !pDiv) begin if (divRise >= 0) divPer = cyc - divRise; divRise = cyc; end
    if (refOut && !pRef) begin if (refRise >= 0) refPer = cyc - refRise; refRise = cyc; end
    if (progZero && !pZ) begin if (zRise >= 0) zPer = cyc - zRise; zRise = cyc; end
    pDiv = divOut; pRef = refOut; pZ = progZero;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clearTrack();
  endtask

  // R3: outputs low during reset, even after running
  task automatic testReset();
    ratioSel = 2'b00; cascadeEn = 1'b0; extTick = 1'b1;
    doReset();
    repeat (3) step("R2 warmup");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(divOut == 0, "R3 divOut in reset", int'(divOut), 0);
    check(progZero == 0, "R3 progZero in reset", int'(progZero), 0);
    check(refOut == 0, "R3 refOut in reset", int'(refOut), 0);
    rst = 1'b0; clearTrack();
    extTick = 1'b0;
  endtask

  // R1 and R2: each ratio for three periods
  task automatic testRatios();
    for (int s = 0; s < 4; s++) begin
      int n;
      ratioSel = 2'(s); cascadeEn = 1'b0; extTick = 1'b0;
      n = ratioOf(2'(s));
      doReset();
      repeat (n) step("R2 first period");
      check(highCnt == n / 2, "R2 high cycles per period", highCnt, n / 2);
      repeat (2 * n) step("R1 run");
      check(divPer == n, "R1 divOut period", divPer, n);
    end
  endtask

  // R4: select change mid-period waits for the wrap
  task automatic testRatioChange();
    ratioSel = 2'b11; cascadeEn = 1'b0;
    doReset();
    repeat (30) step("R4 before change");
    ratioSel = 2'b00;
    repeat (70) step("R4 old ratio completes");
    check(divOut == 0 && divPer == 0, "R4 no early rise", divPer, 0);
    repeat (12) step("R4 new ratio");
    check(divPer == 4, "R4 new period", divPer, 4);
  endtask

  // R5, R6, R9: cascade with extTick held high
  task automatic testCascade();
    ratioSel = 2'b00; cascadeEn = 1'b1; progN = 4'd3; extTick = 1'b1;
    doReset();
    repeat (60) step("R9 cascade ignores extTick");
    check(refPer == 12, "R5 cascade ref period", refPer, 12);
    check(zPer == 12, "R6 progZero period", zPer, 12);
    extTick = 1'b0;
  endtask

  // R7: value 0 behaves as 1
  task automatic testZeroN();
    ratioSel = 2'b01; cascadeEn = 1'b1; progN = 4'd0;
    doReset();
    repeat (60) step("R7 progN zero");
    check(refPer == 16, "R7 ref period with progN 0", refPer, 16);
  endtask

  // R8: independent mode, sparse extTick
  task automatic testIndependent();
    ratioSel = 2'b00; cascadeEn = 1'b0; progN = 4'd5;
    doReset();
    for (int i = 0; i < 40; i++) begin
      extTick = (i % 2 == 0);
      step("R8 independent");
    end
    extTick = 1'b1;
    repeat (20) step("R8 dense ticks");
    check(zPer == 5, "R8 progZero period", zPer, 5);
    check(divPer == 4, "R8 divOut period", divPer, 4);
    extTick = 1'b0;
  endtask

  initial begin
    testReset();
    testRatios();
    testRatioChange();
    testCascade();
    testZeroN();
    testIndependent();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule